// File: doc/BRIEF.md
# Asynchronous serial transmitter with enable-gated break

The block turns bytes written into a one-entry holding register into asynchronous serial frames. Each frame has a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from an external tick. Each bit lasts a parameterised number of ticks, so the tick rate and `TICKS_PER_BIT` together set the baud rate.

Two flags report progress. `empty_o` rises when the holding register is copied into the shifter. `tend_o` rises as the stop period of a frame begins, if no further byte is waiting. Software can therefore see the last frame draining while its stop bit is still on the line.

The transmit enable is the abort and break control. Dropping it gives the pin to a port data bit at once, under a two-bit port mode. The frame in flight is cut short and the transmitter returns to its initial state. Driving the port data bit low while the enable is off produces a continuous break.

Top module: `uart_tx_brk`

## Requirements
- R1: During and right after reset, `empty_o` is 1 and `tend_o` is 1.
- R2: A frame is one low start bit, then `DATA_W` data bits least significant first, then the stop bit(s) at 1. Each bit lasts `TICKS_PER_BIT` ticks. The start bit is on the line in the cycle after the edge that moves the byte into the shifter.
- R3: When `par_en_i` is 1 at frame start, a parity bit follows the data. It equals the XOR of the data bits when `par_odd_i` is 0 (even), and the inverse of that when `par_odd_i` is 1 (odd).
- R4: When `two_stop_i` is 1 at frame start, the frame ends with two stop bits; otherwise it ends with one. Parity and stop settings are captured at frame start.
- R5: With `te_i` high and nothing being sent, `txd_o` is 1.
- R6: The edge that copies the holding register into the shifter sets `empty_o`. A write with `te_i` high clears `empty_o` at the next edge. When the shifter is idle, a written byte is loaded on the edge after the write.
- R7: At the edge where the first stop bit begins, `tend_o` is set if the holding register is empty. A write clears `tend_o`, and a write takes priority over the set in the same cycle.
- R8: A byte written before the last stop bit ends starts its start bit directly after that stop bit, with no idle bit in between.
- R9: With `te_i` low, `txd_o` follows the port selection in the same cycle. The frame in progress and any held byte are discarded. Writes are ignored, and from the next edge `empty_o` and `tend_o` read 1.
- R10: Port mode encoding with `te_i` low: 2'b01 drives `port_dat_i` onto `txd_o`; 2'b00, 2'b10 and 2'b11 leave the line high. Mode 2'b01 with data 0 gives a continuous break.
- R11: If `te_i` is dropped at least `TICKS_PER_BIT/2` ticks after `tend_o` rises (`3*TICKS_PER_BIT/2` with two stop bits), the stop level is held through the receiver's sampling point. Dropping it earlier replaces the rest of the stop bit with the port level.
- R12: The transmitter moves on to the next bit only on cycles where `tick_i` is 1. Cycles without a tick stretch the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-timing tick, one cycle wide |
| te_i | input | 1 | Transmit enable; low aborts and gives the pin to the port |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | DATA_W | Byte to send |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| port_dat_i | input | 1 | Pin level used while the transmitter is disabled |
| port_mode_i | input | 2 | Pin mode while disabled: 2'b01 drives port_dat_i, others leave the line high |
| txd_o | output | 1 | Serial line |
| empty_o | output | 1 | Holding register empty |
| tend_o | output | 1 | Transmission end flag |

## Verification
The bench builds the block with `DATA_W` = 8 and `TICKS_PER_BIT` = 4. With these values a half-bit is two ticks and a stop period of one and a half bits is six ticks. This makes the early and on-time enable-drop cases easy to place to the exact cycle. With a tick on every cycle, each bit is four clocks long, so full frames with parity and two stop bits fit in a few dozen cycles. A tick divided by three exercises R12 without making the run long.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } tx_state_e;

  localparam logic [1:0] PM_DRIVE = 2'b01;
endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign bit_end_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (wr_i) begin
      full_q <= 1'b1;
      data_q <= wdata_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_end_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              load_o,
  output logic              stop_entry_o,
  output logic              line_o
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  tx_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [IW-1:0]     idx_q;
  logic              par_on_q, par_bit_q, two_q;
  logic              done;

  assign done = bit_end_i && ((st_q == ST_STOP1 && !two_q) || st_q == ST_STOP2);
  assign load_o = en_i && full_i && (st_q == ST_IDLE || done);
  // first stop bit begins at this edge
  assign stop_entry_o = en_i && bit_end_i &&
                        ((st_q == ST_DATA && idx_q == LAST_IDX && !par_on_q) ||
                         st_q == ST_PAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      idx_q     <= '0;
      par_on_q  <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
    end else if (!en_i) begin
      st_q <= ST_IDLE;
    end else if (load_o) begin
      st_q      <= ST_START;
      sh_q      <= data_i;
      idx_q     <= '0;
      par_on_q  <= par_en_i;
      par_bit_q <= (^data_i) ^ par_odd_i;
      two_q     <= two_stop_i;
    end else if (bit_end_i) begin
      unique case (st_q)
        ST_START: begin
          st_q  <= ST_DATA;
          idx_q <= '0;
        end
        ST_DATA: begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) st_q <= par_on_q ? ST_PAR : ST_STOP1;
        end
        ST_PAR:   st_q <= ST_STOP1;
        ST_STOP1: st_q <= two_q ? ST_STOP2 : ST_IDLE;
        ST_STOP2: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_bit_q;
      default:  line_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              te_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              port_dat_i,
  input  logic [1:0]        port_mode_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              tend_o
);
  logic              full, load, stop_entry, line, bit_end;
  logic [DATA_W-1:0] hold_data;
  logic              tend_q, port_lvl;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (te_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .take_i  (load),
    .full_o  (full),
    .data_o  (hold_data)
  );

  uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load || !te_i),
    .tick_i    (tick_i),
    .bit_end_o (bit_end)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (te_i),
    .bit_end_i    (bit_end),
    .full_i       (full),
    .data_i       (hold_data),
    .par_en_i     (par_en_i),
    .par_odd_i    (par_odd_i),
    .two_stop_i   (two_stop_i),
    .load_o       (load),
    .stop_entry_o (stop_entry),
    .line_o       (line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tend_q <= 1'b1;
    else if (!te_i)               tend_q <= 1'b1;
    else if (wr_i)                tend_q <= 1'b0;
    else if (stop_entry && !full) tend_q <= 1'b1;
  end

  assign port_lvl = (port_mode_i == PM_DRIVE) ? port_dat_i : 1'b1;
  assign txd_o    = te_i ? line : port_lvl;
  assign empty_o  = !full;
  assign tend_o   = tend_q;
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic te_i,
  input logic wr_i,
  input logic txd_o,
  input logic empty_o,
  input logic tend_o
);
  // R9: disabled transmitter reports empty and ended
  p_disable_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !te_i |=> (empty_o && tend_o));

  // R6 / R7: a write clears both flags
  p_write_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && wr_i) |=> (!empty_o && !tend_o));

  // R2: load into shifter puts the start bit on the line
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && $past(te_i) && $rose(empty_o)) |-> !txd_o);

  // R7: end flag rises while the line carries a stop level
  p_tend_stop_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && $rose(tend_o)) |-> txd_o);

  // R5: nothing pending while enabled keeps the line high
  p_idle_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && tend_o && empty_o) |-> txd_o);

  p_known_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({txd_o, empty_o, tend_o}));
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .te_i    (te_i),
  .wr_i    (wr_i),
  .txd_o   (txd_o),
  .empty_o (empty_o),
  .tend_o  (tend_o)
);

// File: tb/sim_uart_tx_brk.sv
module sim_uart_tx_brk;
  localparam int DW  = 8;
  localparam int TPB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, te = 1'b0, wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic port_dat = 1'b1;
  logic [1:0] port_mode = 2'b00;
  logic txd, empty, tend;

  int n_checks = 0, n_fail = 0, cyc = 0, tick_div = 1;
  string cur_req = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  uart_tx_brk #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .te_i(te), .wr_i(wr),
    .wdata_i(wdata), .par_en_i(par_en), .par_odd_i(par_odd),
    .two_stop_i(two_stop), .port_dat_i(port_dat), .port_mode_i(port_mode),
    .txd_o(txd), .empty_o(empty), .tend_o(tend));

  task automatic chk(string req, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // behavioural reference
  bit m_busy = 0, m_full = 0, m_tend = 1;
  bit m_bits[0:15];
  int m_idx = 0, m_tk = 0, m_n = 0, m_first = 0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n || !te) begin
      m_busy = 0; m_full = 0; m_tend = 1;
    end else begin
      if (m_busy && tick) begin
        m_tk++;
        if (m_tk == TPB) begin
          m_tk = 0; m_idx++;
          if (m_idx == m_first && !m_full) m_tend = 1;
          if (m_idx == m_n) m_busy = 0;
        end
      end
      if (!m_busy && m_full) begin
        m_bits[0] = 1'b0;
        for (int i = 0; i < DW; i++) m_bits[1+i] = m_data[i];
        m_n = 1 + DW;
        if (par_en) begin m_bits[m_n] = (^m_data) ^ par_odd; m_n++; end
        m_first = m_n;
        m_bits[m_n] = 1'b1; m_n++;
        if (two_stop) begin m_bits[m_n] = 1'b1; m_n++; end
        m_busy = 1; m_idx = 0; m_tk = 0; m_full = 0;
      end
      if (wr) begin m_full = 1; m_data = wdata; m_tend = 0; end
    end
  end

  function automatic logic exp_txd();
    if (!te) return (port_mode == 2'b01) ? port_dat : 1'b1;
    return m_busy ? m_bits[m_idx] : 1'b1;
  endfunction

  always begin
    @(negedge clk); #1;
    if (rst_n && !finished) begin
      chk(cur_req, txd, exp_txd(), "txd");
      chk("R6", empty, !m_full, "empty");
      chk("R7", tend, m_tend, "tend");
    end
  end

  // tick source
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 0);
      tc = (tc + 1 >= tick_div) ? 0 : tc + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic send(logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_tend();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (tend) break;
    end
  endtask

  task automatic frame(logic [DW-1:0] d);
    send(d);
    wait_tend();
    idle(3 * TPB * tick_div + 2);
  endtask

  initial begin
    idle(2); #1;
    chk("R1", empty, 1'b1, "empty in reset");
    chk("R1", tend, 1'b1, "tend in reset");
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", empty, 1'b1, "empty after reset");
    chk("R1", tend, 1'b1, "tend after reset");

    cur_req = "R5";
    @(negedge clk); te = 1'b1; port_mode = 2'b01; port_dat = 1'b0;
    #1; chk("R5", txd, 1'b1, "idle line with port low");
    idle(8);

    cur_req = "R2";
    send(8'hA5); #1;
    chk("R6", empty, 1'b0, "empty after write");
    chk("R7", tend, 1'b0, "tend after write");
    @(negedge clk); #1;
    chk("R6", empty, 1'b1, "empty after load");
    chk("R2", txd, 1'b0, "start bit");
    wait_tend(); idle(3 * TPB);
    frame(8'h00); frame(8'hFF);

    cur_req = "R3";
    par_en = 1'b1; par_odd = 1'b0; frame(8'h3C); frame(8'h01);
    par_odd = 1'b1; frame(8'h3C); frame(8'h01);
    par_en = 1'b0;

    cur_req = "R4";
    two_stop = 1'b1; frame(8'h5A);
    par_en = 1'b1; frame(8'h81); par_en = 1'b0; two_stop = 1'b0;

    cur_req = "R8";
    send(8'h11);
    idle(2);
    send(8'h22);
    #1; chk("R8", tend, 1'b0, "tend held low with byte queued");
    wait_tend(); idle(3 * TPB);

    cur_req = "R12";
    tick_div = 3;
    idle(4);
    frame(8'hC3);
    tick_div = 1;
    idle(4);

    cur_req = "R9";
    port_mode = 2'b00; port_dat = 1'b0;
    send(8'h00); idle(6);
    te = 1'b0; #1;
    chk("R9", txd, 1'b1, "disabled pin mode 00");
    send(8'h55); idle(2); #1;
    chk("R9", empty, 1'b1, "write ignored while disabled");
    chk("R9", tend, 1'b1, "tend while disabled");
    @(negedge clk); te = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < 12 * TPB; i++) begin
        @(negedge clk); #1;
        if (txd == 1'b0) lows++;
      end
      n_checks++;
      if (lows != 0) begin
        n_fail++;
        $display("FAIL R9 low cycles after re-enable actual=%0d expected=0", lows);
      end
    end

    cur_req = "R10";
    @(negedge clk); te = 1'b0; port_mode = 2'b01; port_dat = 1'b0;
    for (int i = 0; i < 16; i++) begin
      #1; chk("R10", txd, 1'b0, "break level");
      @(negedge clk);
    end
    port_mode = 2'b10; #1; chk("R10", txd, 1'b1, "mode 10");
    @(negedge clk); port_mode = 2'b11; #1; chk("R10", txd, 1'b1, "mode 11");
    @(negedge clk); port_mode = 2'b00; #1; chk("R10", txd, 1'b1, "mode 00");
    @(negedge clk); port_mode = 2'b01; port_dat = 1'b1; #1; chk("R10", txd, 1'b1, "mode 01 data 1");

    // R11: on-time drop, one stop bit
    cur_req = "R11";
    @(negedge clk); te = 1'b1; port_dat = 1'b0;
    send(8'h96); wait_tend();
    for (int i = 0; i < TPB / 2; i++) begin
      chk("R11", txd, 1'b1, "stop held, one stop");
      @(negedge clk);
    end
    te = 1'b0; #1; chk("R11", txd, 1'b0, "port takes pin");
    idle(4);

    // R11: on-time drop, two stop bits
    @(negedge clk); te = 1'b1; two_stop = 1'b1;
    send(8'h69); wait_tend();
    for (int i = 0; i < 3 * TPB / 2; i++) begin
      chk("R11", txd, 1'b1, "stop held, two stops");
      @(negedge clk);
    end
    te = 1'b0; #1; chk("R11", txd, 1'b0, "port takes pin");
    idle(4);

    // R11: early drop truncates the stop bit before its midpoint
    @(negedge clk); te = 1'b1; two_stop = 1'b0;
    send(8'hF0); wait_tend();
    @(negedge clk); te = 1'b0;
    idle(TPB / 2 - 1); #1;
    chk("R11", txd, 1'b0, "stop midpoint after early drop");
    idle(4);
    @(negedge clk); te = 1'b1; port_mode = 2'b00;
    idle(4); #1;
    chk("R11", tend, 1'b1, "tend after re-enable");

    finished = 1;
    summary();
    $finish;
  end
endmodule